// File: doc/BRIEF.md
# Real-Mode Interrupt Frame Sequencer

This block carries out the memory traffic for entering a real-mode interrupt handler and for leaving it again with an interrupt return. A one-cycle request starts a sequence. The block captures the current instruction pointer, code segment, stack pointer, stack segment, 16-bit flags word and the separately held alignment-check bit. For an interrupt, it pushes three words onto the stack and then fetches the handler's offset and segment from the fixed vector table at the bottom of physical memory. For a return, it pops the three words back off the stack.

The memory side is one word-wide port. Each access is held until the memory answers with ready. When a sequence ends, the block pulses `done_o` for one cycle. In that cycle the new IP, CS, SP, flags and alignment-check bit are on the outputs, and the surrounding core loads them.

Top module: `rm_intr_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_req_o` and `mem_we_o` are all 0.
- R2: An interrupt writes three words in this order: the captured flags, then CS, then IP. Before each write, SP is decreased by 2, so the words land at SP-2, SP-4 and SP-6 of the stack segment. The resulting `sp_o` is SP-6.
- R3: The handler offset is read from byte address vector×4 and the handler segment from vector×4+2. These reads come after the three pushes and become `ip_o` and `cs_o`.
- R4: On interrupt completion, `flags_o` equals the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared and every other bit kept. `ac_o` is 0.
- R5: A return reads IP at SP, CS at SP+2 and flags at SP+4, in that order, and performs no write. It yields `sp_o` = SP+6. `ac_o` keeps the captured `ac_i`.
- R6: SP arithmetic wraps modulo 2^16 inside the stack segment. Pushing from SP=0x0000 writes at offset 0xFFFE first. Popping from 0xFFFC reads offsets 0xFFFC, 0xFFFE, then 0x0000.
- R7: A stack address is SS×16 plus the offset. With `ADDR_WRAP`=1 (default), bit 20 is dropped, so 0xFFFF:0x001E reaches 0x0000E.
- R8: While `mem_ready_i` is low, an access keeps `mem_req_o`, address, write data and write enable unchanged. Results do not depend on the number of wait cycles.
- R9: Requests that arrive while a sequence is running are ignored. They produce no extra access and no extra `done_o`.
- R10: If an interrupt request and a return request arrive in the same idle cycle, the interrupt is taken.
- R11: `done_o` is high for exactly one cycle per sequence, and `busy_o` only falls right after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Start interrupt entry (sampled when idle) |
| irq_vec_i | input | 8 | Interrupt vector number |
| iret_req_i | input | 1 | Start interrupt return (sampled when idle) |
| ip_i | input | 16 | Current instruction pointer |
| cs_i | input | 16 | Current code segment |
| sp_i | input | 16 | Current stack pointer |
| ss_i | input | 16 | Current stack segment |
| flags_i | input | 16 | Current flags word |
| ac_i | input | 1 | Current alignment-check bit |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Byte address (21 when ADDR_WRAP=0) |
| mem_wdata_o | output | 16 | Write word |
| mem_rdata_i | input | 16 | Read word, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ip_o | output | 16 | New instruction pointer |
| cs_o | output | 16 | New code segment |
| sp_o | output | 16 | New stack pointer |
| flags_o | output | 16 | New flags word |
| ac_o | output | 1 | New alignment-check bit |

## Verification
The sequencer is tried with a mid-memory interrupt whose flags have both bit 9 and bit 8 set. It is also tried with a return from a prepared stack frame, and with an entry followed by a return, which must restore the original state. Two frames test the boundaries: one placed at SP=0 and SP=0xFFFC, which separates 16-bit offset wrap from segment carry, and one at 0xFFFF:0x0020, which checks that bit 20 is dropped. Runs with three wait cycles, overlapping requests and a simultaneous interrupt-and-return request show that timing, request filtering and priority do not change which addresses are accessed or what results come back.

// File: rtl/rmint_pkg.sv
package rmint_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_RD_OFF, S_RD_SEG,
    S_POP_IP, S_POP_CS, S_POP_FL, S_DONE
  } seq_state_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned IF_BIT = 9;
  localparam int unsigned TF_BIT = 8;
  localparam int unsigned SEG_SHIFT = 4;
endpackage

// File: rtl/rmint_phys_addr.sv
module rmint_phys_addr #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter bit          WRAP  = 1'b1,
  localparam int unsigned FULL_W = SEG_W + SHIFT + 1,
  localparam int unsigned OUT_W  = WRAP ? FULL_W - 1 : FULL_W
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [OUT_W-1:0] addr_o
);
  logic [FULL_W-1:0] sum;
  assign sum = (FULL_W'(seg_i) << SHIFT) + FULL_W'(off_i);

  generate
    if (WRAP) begin : g_wrap
      assign addr_o = sum[FULL_W-2:0];
    end else begin : g_full
      assign addr_o = sum;
    end
  endgenerate
endmodule

// File: rtl/rmint_flag_mask.sv
module rmint_flag_mask #(
  parameter int unsigned W      = 16,
  parameter int unsigned IF_POS = 9,
  parameter int unsigned TF_POS = 8
) (
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] clr;
  always_comb begin
    clr         = '0;
    clr[IF_POS] = 1'b1;
    clr[TF_POS] = 1'b1;
  end
  assign flags_o = flags_i & ~clr;
endmodule

// File: rtl/rm_intr_seq.sv
module rm_intr_seq
  import rmint_pkg::*;
#(
  parameter bit          ADDR_WRAP = 1'b1,
  parameter int unsigned VEC_W     = 8,
  localparam int unsigned AW = ADDR_WRAP ? 20 : 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic              iret_req_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic              ac_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] flags_o,
  output logic              ac_o
);
  seq_state_e        state_q;
  logic              entry_q;
  logic [WORD_W-1:0] ip_q, cs_q, sp_q, ss_q, fl_q;
  logic              ac_q;
  logic [VEC_W-1:0]  vec_q;

  logic [WORD_W-1:0] sp_dec, sp_inc, stk_off, fl_masked;
  logic [AW-1:0]     stk_addr, tbl_addr;
  logic              is_push, is_pop, is_tbl, xfer;

  assign sp_dec = sp_q - WORD_W'(2);
  assign sp_inc = sp_q + WORD_W'(2);

  assign is_push = (state_q == S_PUSH_FL) || (state_q == S_PUSH_CS) || (state_q == S_PUSH_IP);
  assign is_pop  = (state_q == S_POP_IP)  || (state_q == S_POP_CS)  || (state_q == S_POP_FL);
  assign is_tbl  = (state_q == S_RD_OFF)  || (state_q == S_RD_SEG);

  // pushes pre-decrement, pops use current SP
  assign stk_off = is_push ? sp_dec : sp_q;

  rmint_phys_addr #(
    .SEG_W(WORD_W), .OFF_W(WORD_W), .SHIFT(SEG_SHIFT), .WRAP(ADDR_WRAP)
  ) u_stk_addr (
    .seg_i (ss_q),
    .off_i (stk_off),
    .addr_o(stk_addr)
  );

  assign tbl_addr = AW'({vec_q, 2'b00}) + ((state_q == S_RD_SEG) ? AW'(2) : AW'(0));

  rmint_flag_mask #(.W(WORD_W), .IF_POS(IF_BIT), .TF_POS(TF_BIT)) u_fmask (
    .flags_i(fl_q),
    .flags_o(fl_masked)
  );

  always_comb begin
    mem_req_o   = is_push || is_pop || is_tbl;
    mem_we_o    = is_push;
    mem_addr_o  = is_tbl ? tbl_addr : (mem_req_o ? stk_addr : '0);
    unique case (state_q)
      S_PUSH_FL: mem_wdata_o = fl_q;
      S_PUSH_CS: mem_wdata_o = cs_q;
      S_PUSH_IP: mem_wdata_o = ip_q;
      default:   mem_wdata_o = '0;
    endcase
  end

  assign xfer   = mem_req_o && mem_ready_i;
  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      entry_q <= 1'b0;
      ip_q    <= '0;
      cs_q    <= '0;
      sp_q    <= '0;
      ss_q    <= '0;
      fl_q    <= '0;
      ac_q    <= 1'b0;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (irq_req_i || iret_req_i) begin
            ip_q  <= ip_i;
            cs_q  <= cs_i;
            sp_q  <= sp_i;
            ss_q  <= ss_i;
            fl_q  <= flags_i;
            ac_q  <= ac_i;
            vec_q <= irq_vec_i;
            entry_q <= irq_req_i;
            state_q <= irq_req_i ? S_PUSH_FL : S_POP_IP;
          end
        end
        S_PUSH_FL: if (xfer) begin
          sp_q    <= sp_dec;
          fl_q    <= fl_masked;
          ac_q    <= 1'b0;
          state_q <= S_PUSH_CS;
        end
        S_PUSH_CS: if (xfer) begin
          sp_q    <= sp_dec;
          state_q <= S_PUSH_IP;
        end
        S_PUSH_IP: if (xfer) begin
          sp_q    <= sp_dec;
          state_q <= S_RD_OFF;
        end
        S_RD_OFF: if (xfer) begin
          ip_q    <= mem_rdata_i;
          state_q <= S_RD_SEG;
        end
        S_RD_SEG: if (xfer) begin
          cs_q    <= mem_rdata_i;
          state_q <= S_DONE;
        end
        S_POP_IP: if (xfer) begin
          ip_q    <= mem_rdata_i;
          sp_q    <= sp_inc;
          state_q <= S_POP_CS;
        end
        S_POP_CS: if (xfer) begin
          cs_q    <= mem_rdata_i;
          sp_q    <= sp_inc;
          state_q <= S_POP_FL;
        end
        S_POP_FL: if (xfer) begin
          fl_q    <= mem_rdata_i;
          sp_q    <= sp_inc;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ip_o    = ip_q;
  assign cs_o    = cs_q;
  assign sp_o    = sp_q;
  assign flags_o = fl_q;
  assign ac_o    = ac_q;

  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_wdata_o) && $stable(mem_we_o)));

  // R4
  entry_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && entry_q) |-> (!flags_o[IF_BIT] && !flags_o[TF_BIT] && !ac_o));

  // R5
  iret_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o) |-> entry_q);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

  // R2
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_ready_i) |=> (sp_o == $past(sp_o) - 16'd2));
endmodule

// File: tb/sim_rm_intr_seq.sv
module sim_rm_intr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, iret_req = 1'b0, ac_in = 1'b0;
  logic [7:0]  vec = '0;
  logic [15:0] ip_in = '0, cs_in = '0, sp_in = '0, ss_in = '0, fl_in = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic        busy, done, ac_out;
  logic [15:0] ip_out, cs_out, sp_out, fl_out;

  int total = 0, bad = 0;
  int wait_n = 0, wcnt = 0, n_log = 0, n_done = 0;
  logic [15:0] mem [int];
  logic [19:0] log_addr [32];
  logic [15:0] log_data [32];
  logic        log_we   [32];
  logic [15:0] r_ip, r_cs, r_sp, r_fl;
  logic        r_ac;

  always #2 clk = ~clk;

  rm_intr_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_vec_i(vec),
    .iret_req_i(iret_req), .ip_i(ip_in), .cs_i(cs_in), .sp_i(sp_in), .ss_i(ss_in),
    .flags_i(fl_in), .ac_i(ac_in), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .busy_o(busy), .done_o(done), .ip_o(ip_out),
    .cs_o(cs_out), .sp_o(sp_out), .flags_o(fl_out), .ac_o(ac_out)
  );

  // memory model: decides ready on the falling edge
  always @(negedge clk) begin
    if (done) n_done++;
    if (mem_req) begin
      if (wcnt >= wait_n) begin
        mem_ready = 1'b1;
        wcnt = 0;
        if (n_log < 32) begin
          log_addr[n_log] = mem_addr;
          log_data[n_log] = mem_we ? mem_wdata : (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0);
          log_we[n_log]   = mem_we;
        end
        n_log++;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wcnt = 0;
    end
  end

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'h0} + {5'h0, off};
    return s[19:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        r_ip = ip_out; r_cs = cs_out; r_sp = sp_out; r_fl = fl_out; r_ac = ac_out;
      end
    end
    check("R11 done seen", 32'(seen), 32'd1);
    @(negedge clk);
    check("R11 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic launch(input bit irq, input bit iret, input logic [7:0] v,
                        input logic [15:0] ip, input logic [15:0] cs, input logic [15:0] sp,
                        input logic [15:0] ss, input logic [15:0] fl, input bit ac);
    @(negedge clk);
    n_log = 0; n_done = 0;
    vec = v; ip_in = ip; cs_in = cs; sp_in = sp; ss_in = ss; fl_in = fl; ac_in = ac;
    irq_req = irq; iret_req = iret;
    @(negedge clk);
    irq_req = 0; iret_req = 0;
  endtask

  task automatic chk_entry(input string tag, input logic [7:0] v, input logic [15:0] ip,
                           input logic [15:0] cs, input logic [15:0] sp, input logic [15:0] ss,
                           input logic [15:0] fl, input logic [15:0] h_off, input logic [15:0] h_seg);
    check({tag, " R2 access count"}, n_log, 5);
    check({tag, " R2 push1 addr"}, log_addr[0], phys(ss, sp - 16'd2));
    check({tag, " R2 push1 flags"}, {log_we[0], log_data[0]}, {1'b1, fl});
    check({tag, " R2 push2 addr"}, log_addr[1], phys(ss, sp - 16'd4));
    check({tag, " R2 push2 cs"}, {log_we[1], log_data[1]}, {1'b1, cs});
    check({tag, " R2 push3 addr"}, log_addr[2], phys(ss, sp - 16'd6));
    check({tag, " R2 push3 ip"}, {log_we[2], log_data[2]}, {1'b1, ip});
    check({tag, " R3 off addr"}, {log_we[3], log_addr[3]}, {1'b0, 10'h0, v, 2'b00});
    check({tag, " R3 seg addr"}, {log_we[4], log_addr[4]}, {1'b0, 10'h0, v, 2'b10});
    check({tag, " R3 ip_o"}, r_ip, h_off);
    check({tag, " R3 cs_o"}, r_cs, h_seg);
    check({tag, " R2 sp_o"}, r_sp, sp - 16'd6);
    check({tag, " R4 flags_o"}, r_fl, fl & 16'hFCFF);
    check({tag, " R4 ac_o"}, r_ac, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 req/we", {mem_req, mem_we}, 0);
  endtask

  task automatic t_entry_basic();
    mem[32'h84] = 16'h1234; mem[32'h86] = 16'hABCD;
    launch(1, 0, 8'h21, 16'h0100, 16'h2000, 16'h0100, 16'h3000, 16'h03D5, 1);
    wait_done();
    chk_entry("basic", 8'h21, 16'h0100, 16'h2000, 16'h0100, 16'h3000, 16'h03D5, 16'h1234, 16'hABCD);
  endtask

  task automatic t_iret_basic();
    mem[32'h10200] = 16'h5555; mem[32'h10202] = 16'h6666; mem[32'h10204] = 16'h0F02;
    launch(0, 1, 8'h00, 16'h0, 16'h0, 16'h0200, 16'h1000, 16'h0, 1);
    wait_done();
    check("R5 access count", n_log, 3);
    check("R5 pop ip addr", {log_we[0], log_addr[0]}, {1'b0, 20'h10200});
    check("R5 pop cs addr", {log_we[1], log_addr[1]}, {1'b0, 20'h10202});
    check("R5 pop fl addr", {log_we[2], log_addr[2]}, {1'b0, 20'h10204});
    check("R5 ip/cs", {r_ip, r_cs}, {16'h5555, 16'h6666});
    check("R5 flags", r_fl, 16'h0F02);
    check("R5 sp", r_sp, 16'h0206);
    check("R5 ac kept", r_ac, 1);
  endtask

  task automatic t_roundtrip();
    mem[32'h20] = 16'h0777; mem[32'h22] = 16'h0888;
    launch(1, 0, 8'h08, 16'hBEEF, 16'hCAFE, 16'h0400, 16'h2200, 16'h0B13, 0);
    wait_done();
    launch(0, 1, 8'h00, r_ip, r_cs, r_sp, 16'h2200, r_fl, 0);
    wait_done();
    check("R5 roundtrip ip/cs", {r_ip, r_cs}, {16'hBEEF, 16'hCAFE});
    check("R5 roundtrip flags/sp", {r_fl, r_sp}, {16'h0B13, 16'h0400});
  endtask

  task automatic t_wrap_sp();
    mem[32'h40] = 16'h0011; mem[32'h42] = 16'h0022;
    launch(1, 0, 8'h10, 16'h0A0A, 16'h0B0B, 16'h0000, 16'h4000, 16'h0200, 0);
    wait_done();
    check("R6 push addrs", {log_addr[0], log_addr[1], log_addr[2]}, {20'h4FFFE, 20'h4FFFC, 20'h4FFFA});
    check("R6 sp_o", r_sp, 16'hFFFA);
    mem[32'h40000] = 16'h0F0F;
    launch(0, 1, 8'h00, 16'h0, 16'h0, 16'hFFFC, 16'h4000, 16'h0, 0);
    wait_done();
    check("R6 pop addrs", {log_addr[0], log_addr[1], log_addr[2]}, {20'h4FFFC, 20'h4FFFE, 20'h40000});
    check("R6 pop sp", r_sp, 16'h0002);
    check("R6 pop data", {r_ip, r_cs, r_fl}, {16'h0B0B, 16'h0200, 16'h0F0F});
  endtask

  task automatic t_a20();
    mem[32'h0] = 16'h4321; mem[32'h2] = 16'h8765;
    launch(1, 0, 8'h00, 16'h1111, 16'h2222, 16'h0020, 16'hFFFF, 16'h0000, 0);
    wait_done();
    check("R7 wrapped push1", log_addr[0], 20'h0000E);
    check("R7 wrapped push3", log_addr[2], 20'h0000A);
    check("R7 handler", {r_ip, r_cs}, {16'h4321, 16'h8765});
  endtask

  task automatic t_wait();
    wait_n = 3;
    mem[32'h3FC] = 16'h9A9A; mem[32'h3FE] = 16'hB0B0;
    launch(1, 0, 8'hFF, 16'h0042, 16'h1357, 16'h0800, 16'h5000, 16'hFFFF, 1);
    wait_done();
    chk_entry("R8 waits", 8'hFF, 16'h0042, 16'h1357, 16'h0800, 16'h5000, 16'hFFFF, 16'h9A9A, 16'hB0B0);
    wait_n = 0;
  endtask

  task automatic t_busy_ignore();
    wait_n = 2;
    mem[32'h30] = 16'h0303; mem[32'h32] = 16'h0404;
    launch(1, 0, 8'h0C, 16'h0001, 16'h0002, 16'h0600, 16'h6000, 16'h0000, 0);
    @(negedge clk);
    irq_req = 1; iret_req = 1; vec = 8'h55;
    repeat (4) @(negedge clk);
    irq_req = 0; iret_req = 0;
    wait_done();
    repeat (8) @(negedge clk);
    check("R9 accesses", n_log, 5);
    check("R9 done count", n_done, 1);
    check("R9 idle after", {busy, mem_req}, 0);
    check("R9 handler", {r_ip, r_cs}, {16'h0303, 16'h0404});
    wait_n = 0;
  endtask

  task automatic t_both();
    mem[32'h14] = 16'h0E0E; mem[32'h16] = 16'h0D0D;
    launch(1, 1, 8'h05, 16'h0123, 16'h0456, 16'h0700, 16'h7000, 16'h0100, 0);
    wait_done();
    check("R10 entry taken", {log_we[0], n_log[7:0]}, {1'b1, 8'd5});
    check("R10 handler", {r_ip, r_cs}, {16'h0E0E, 16'h0D0D});
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry_basic();
    t_iret_basic();
    t_roundtrip();
    t_wrap_sp();
    t_a20();
    t_wait();
    t_busy_ignore();
    t_both();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule